// File: doc/BRIEF.md
# Two-Wire Register Access Slave

This block lets an external two-wire bus host (I2C) read and write a bank of up to 128 byte-wide registers that lives outside it. SCL and SDA are first brought into the system clock domain. The block then finds start and stop conditions and checks the device address. The top four address bits are a parameter (default 0010). The low three bits come from strap inputs. After a matching write address, the next byte is a pointer byte. Its top bit turns on auto-increment and its low seven bits select a register. Any further bytes in the write are stored into the bank.

Reads do not carry a pointer of their own. They return bytes starting at whatever register the pointer last held. To read a chosen register, the host first sends a write that stops right after the pointer byte, and then starts a read. A repeated start at any point sends the block back to address matching and leaves the pointer as it was. The block drives SDA only through an active-high pull-low enable. The bank sits on a simple port: an address, a write strobe with data, a read strobe, and combinational read data.

Top module: `i2c_regport`

## Requirements
- R1: A start condition (SDA falls while SCL is high) begins address matching. A stop condition (SDA rises while SCL is high) releases SDA, and the block then ignores clocked bytes until the next start.
- R2: The first byte after a start holds a 7-bit address, MSB first, then a direction bit (1 = read). The block pulls SDA low in the ninth clock only when the address equals 0010 followed by strap[2:0].
- R3: After an address that does not match, SDA stays released and no register is accessed until the next start.
- R4: In a write, the byte after the address is acknowledged and loads the pointer. Bit 7 of that byte is the auto-increment flag and bits 6:0 are the register index.
- R5: Each further byte of a write is acknowledged and gives one single-cycle reg_wr pulse, with reg_addr equal to the pointer and reg_wdata equal to the byte.
- R6: With auto-increment set, the pointer advances by one after each data byte written or read, wrapping from 127 to 0. With it clear, the pointer stays fixed.
- R7: In a read, the block shifts out the register at the pointer, MSB first, and raises reg_rd once for each byte it loads.
- R8: During a read, an acknowledge from the master (SDA low in the ninth clock) makes the block send the next byte. A not-acknowledge makes it release SDA and stop sending.
- R9: A write that stops right after the pointer byte changes only the pointer, and a later read starts from that register.
- R10: A repeated start inside a transaction returns the block to address matching and keeps the pointer value.
- R11: sda_oe is low after reset and changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock as seen on the pin |
| sda_i | input | 1 | Bus data as seen on the pin |
| sda_oe | output | 1 | When high, the pad pulls SDA low |
| strap | input | 3 | Low three bits of the device address |
| reg_addr | output | 7 | Register index (the current pointer) |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Byte to write |
| reg_rd | output | 1 | One-cycle strobe when a read byte is loaded |
| reg_rdata | input | 8 | Combinational read data for reg_addr |

## Verification
The hardest state to reach from the ports is a pointer value that was carried across transactions. This includes a pointer that wrapped from 127 to 0 at the end of a read burst, and a pointer left behind by a write burst that was cut off by a repeated start. The bench gets there by writing all 128 registers with auto-increment on. It then sets the pointer with an aborted write and reads the whole bank back. A fresh read after that must begin at register 0. Separate sequences insert a repeated start after a pointer byte and after a data byte.

// File: rtl/i2c_regport.sv
module i2c_regport #(
  parameter logic [3:0] DEV_HI = 4'b0010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [2:0] strap,
  output logic [6:0] reg_addr,
  output logic       reg_wr,
  output logic [7:0] reg_wdata,
  output logic       reg_rd,
  input  logic [7:0] reg_rdata
);

  typedef enum logic [2:0] {P_IDLE, P_ADDR, P_MAP, P_WR, P_RD} phase_t;

  phase_t     phase;
  logic [2:0] scl_p, sda_p;
  logic [3:0] cnt;
  logic [7:0] shreg, txreg;
  logic [6:0] map_ptr;
  logic       autoinc, rw, nack;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_p <= 3'b111;
      sda_p <= 3'b111;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end

  wire scl_s = scl_p[1];
  wire scl_q = scl_p[2];
  wire sda_s = sda_p[1];
  wire sda_q = sda_p[2];

  wire rise    = scl_s & ~scl_q;
  wire fall    = ~scl_s & scl_q;
  wire start_c = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c  = scl_s & scl_q & ~sda_q & sda_s;

  wire       rx       = (phase == P_ADDR) || (phase == P_MAP) || (phase == P_WR);
  wire       addr_hit = shreg[7:1] == {DEV_HI, strap};
  wire [2:0] bidx     = 3'(4'd7 - cnt);

  assign reg_addr  = map_ptr;
  assign reg_wdata = shreg;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      phase   <= P_IDLE;
      cnt     <= 4'd0;
      shreg   <= 8'd0;
      txreg   <= 8'd0;
      map_ptr <= 7'd0;
      autoinc <= 1'b0;
      rw      <= 1'b0;
      nack    <= 1'b0;
      sda_oe  <= 1'b0;
      reg_wr  <= 1'b0;
      reg_rd  <= 1'b0;
    end else begin
      reg_wr <= 1'b0;
      reg_rd <= 1'b0;
      if (start_c) begin
        phase  <= P_ADDR;
        cnt    <= 4'd0;
        sda_oe <= 1'b0;
      end else if (stop_c) begin
        phase  <= P_IDLE;
        cnt    <= 4'd0;
        sda_oe <= 1'b0;
      end else if (phase != P_IDLE) begin
        if (rise) begin
          if (rx && cnt < 4'd8) shreg <= {shreg[6:0], sda_s};
          if (cnt == 4'd8) nack <= sda_s;
          if (cnt < 4'd9) cnt <= cnt + 4'd1;
        end else if (fall) begin
          if (rx) begin
            if (cnt == 4'd8) begin
              case (phase)
                P_ADDR:
                  if (addr_hit) begin
                    sda_oe <= 1'b1;
                    rw     <= shreg[0];
                  end else begin
                    phase <= P_IDLE;
                  end
                P_MAP: begin
                  sda_oe  <= 1'b1;
                  map_ptr <= shreg[6:0];
                  autoinc <= shreg[7];
                end
                default: begin
                  sda_oe <= 1'b1;
                  reg_wr <= 1'b1;
                end
              endcase
            end else if (cnt == 4'd9) begin
              cnt <= 4'd0;
              case (phase)
                P_ADDR:
                  if (rw) begin
                    phase  <= P_RD;
                    txreg  <= reg_rdata;
                    sda_oe <= ~reg_rdata[7];
                    reg_rd <= 1'b1;
                  end else begin
                    phase  <= P_MAP;
                    sda_oe <= 1'b0;
                  end
                P_MAP: begin
                  phase  <= P_WR;
                  sda_oe <= 1'b0;
                end
                default: begin
                  sda_oe <= 1'b0;
                  if (autoinc) map_ptr <= map_ptr + 7'd1;
                end
              endcase
            end
          end else begin
            if (cnt >= 4'd1 && cnt <= 4'd7) begin
              sda_oe <= ~txreg[bidx];
            end else if (cnt == 4'd8) begin
              sda_oe <= 1'b0;
              if (autoinc) map_ptr <= map_ptr + 7'd1;
            end else if (cnt == 4'd9) begin
              if (nack) begin
                phase <= P_IDLE;
              end else begin
                txreg  <= reg_rdata;
                sda_oe <= ~reg_rdata[7];
                reg_rd <= 1'b1;
                cnt    <= 4'd0;
              end
            end
          end
        end
      end
    end

  assert_oe_low_scl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);

  assert_idle_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == P_IDLE) |-> !sda_oe);

  assert_wr_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);

  assert_wr_in_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> (phase == P_WR) && sda_oe);

  assert_rd_in_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |-> (phase == P_RD));

  assert_rstart_keeps_ptr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start_c |=> $stable(map_ptr));

endmodule

// File: tb/i2c_regport_test.sv
module i2c_regport_test;
  localparam int Q = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [2:0] strap = 3'd0;
  logic sda_oe, reg_wr, reg_rd;
  logic [6:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic [7:0] mem [128];
  logic [7:0] expv [128];
  int checks = 0, errs = 0, wr_count = 0, viol = 0;
  logic prev_oe = 1'b0;

  wire sda_bus = sda_m & ~sda_oe;

  always #4 clk = ~clk;

  i2c_regport uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .strap(strap), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata)
  );

  assign reg_rdata = mem[reg_addr];

  always @(posedge clk)
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) mem[i] <= 8'd0;
    end else if (reg_wr) begin
      mem[reg_addr] <= reg_wdata;
      wr_count <= wr_count + 1;
    end

  always @(negedge clk) begin
    if (sda_oe != prev_oe && scl_m) viol <= viol + 1;
    prev_oe <= sda_oe;
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] ex);
    checks++;
    if (act !== ex) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, ex);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bit_io(input logic b, output logic seen);
    sda_m = b; wq();
    scl_m = 1'b1; wq();
    seen = sda_bus; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic do_start();
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic do_stop();
    sda_m = 1'b0; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_io(b[i], s);
    bit_io(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic nk, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_io(1'b1, s);
      b[i] = s;
    end
    bit_io(nk, s);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] b;
    int w0;
    for (int i = 0; i < 128; i++) expv[i] = 8'd0;
    repeat (5) @(negedge clk);
    chk("R11", "oe in reset", 32'(sda_oe), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11", "oe after reset", 32'(sda_oe), 0);
    chk("R5", "wr after reset", 32'(reg_wr), 0);

    for (int s = 0; s < 8; s++) begin
      strap = 3'(s);
      for (int a = 0; a < 8; a++) begin
        w0 = wr_count;
        do_start();
        send_byte({4'b0010, 3'(a), 1'b0}, ack);
        chk("R2", "address ack", 32'(ack), 32'(a == s));
        if (a != s) begin
          send_byte(8'h05, ack);
          chk("R3", "no ack after miss", 32'(ack), 0);
          send_byte(8'h77, ack);
          chk("R3", "no write after miss", 32'(wr_count - w0), 0);
        end
        do_stop();
      end
      do_start();
      send_byte({4'b0011, 3'(s), 1'b0}, ack);
      chk("R2", "wrong upper bits", 32'(ack), 0);
      do_stop();
    end

    strap = 3'd5;
    do_start();
    send_byte(8'h2A, ack); chk("R2", "write addr ack", 32'(ack), 1);
    send_byte(8'hFE, ack); chk("R4", "map ack", 32'(ack), 1);
    for (int k = 0; k < 4; k++) begin
      send_byte(8'(8'hA0 + k), ack);
      chk("R5", "data ack", 32'(ack), 1);
      expv[(126 + k) % 128] = 8'(8'hA0 + k);
    end
    do_stop();
    for (int k = 0; k < 4; k++)
      chk("R6", "autoinc wrap write", 32'(mem[(126 + k) % 128]), 32'(expv[(126 + k) % 128]));

    w0 = wr_count;
    do_start();
    send_byte(8'h2A, ack);
    send_byte(8'h10, ack);
    send_byte(8'h11, ack); send_byte(8'h22, ack); send_byte(8'h33, ack);
    do_stop();
    expv[16] = 8'h33;
    chk("R6", "fixed ptr target", 32'(mem[16]), 32'h33);
    chk("R6", "fixed ptr neighbour", 32'(mem[17]), 32'(expv[17]));
    chk("R5", "write strobes", 32'(wr_count - w0), 3);

    w0 = wr_count;
    send_byte(8'h2A, ack); chk("R1", "ack after stop", 32'(ack), 0);
    send_byte(8'h00, ack); send_byte(8'h55, ack);
    chk("R1", "writes after stop", 32'(wr_count - w0), 0);

    do_start();
    send_byte(8'h2A, ack);
    send_byte(8'h80, ack);
    for (int k = 0; k < 128; k++) begin
      send_byte(8'(k * 37 + 5), ack);
      expv[k] = 8'(k * 37 + 5);
    end
    do_stop();

    w0 = wr_count;
    do_start(); send_byte(8'h2A, ack); send_byte(8'h80, ack); do_stop();
    chk("R9", "abort writes nothing", 32'(wr_count - w0), 0);
    do_start();
    send_byte(8'h2B, ack); chk("R2", "read addr ack", 32'(ack), 1);
    for (int k = 0; k < 128; k++) begin
      recv_byte(k == 127, b);
      chk("R7", "burst read", 32'(b), 32'(expv[k]));
    end
    chk("R8", "released after nack", 32'(sda_oe), 0);
    do_stop();

    do_start(); send_byte(8'h2B, ack); recv_byte(1'b1, b); do_stop();
    chk("R6", "read ptr wrapped", 32'(b), 32'(expv[0]));

    do_start(); send_byte(8'h2A, ack); send_byte(8'h20, ack); do_stop();
    do_start(); send_byte(8'h2B, ack);
    for (int k = 0; k < 3; k++) begin
      recv_byte(k == 2, b);
      chk("R6", "fixed ptr read", 32'(b), 32'(expv[32]));
    end
    do_stop();

    do_start(); send_byte(8'h2A, ack); send_byte(8'hC0, ack);
    do_start(); send_byte(8'h2B, ack);
    chk("R10", "ack after restart", 32'(ack), 1);
    recv_byte(1'b0, b); chk("R10", "restart read 0", 32'(b), 32'(expv[64]));
    recv_byte(1'b1, b); chk("R10", "restart read 1", 32'(b), 32'(expv[65]));
    do_stop();

    do_start(); send_byte(8'h2A, ack); send_byte(8'h85, ack); send_byte(8'h99, ack);
    expv[5] = 8'h99;
    do_start(); send_byte(8'h2B, ack); recv_byte(1'b1, b); do_stop();
    chk("R10", "restart after data", 32'(b), 32'(expv[6]));
    chk("R5", "restart data stored", 32'(mem[5]), 32'h99);

    chk("R11", "oe changes while scl high", 32'(viol), 0);
    summary();
    $finish;
  end
endmodule